// File: doc/BRIEF.md
# Processor Clock-Control Power State Machine

This block follows the low-power clock-control state of a processor core and runs on the bus clock. It takes a halt indication, an interrupt, a stop-clock request, three nested sleep requests (sleep, deep sleep, deeper sleep), a system-management interrupt with its resume, and reset. It reports the present state as a one-hot vector. It also drives the gating enables for the core clock and the bus-interface clock, a flag that says snoops may be accepted, and a flag that marks a break event waiting while the clock is being stopped.

A stop-clock request is honoured only after it has been held for a fixed number of bus clocks. When it is released, the machine returns to whichever running state it left, either normal or halted. The sleep levels nest strictly. Sleep is reached only from stop-grant, deep sleep only from sleep, and deeper sleep only from deep sleep. Each level falls back one step when its request is dropped, so no level exit depends on counting bus clocks. A system-management interrupt taken from normal or halted execution runs in normal execution, and its resume returns to the state saved on entry.

Top module: `clkctl_pwr_fsm`

## Requirements
- R1: After reset the state output is normal. The bit positions are normal=0, halt=1, stop-grant=2, sleep=3, deep sleep=4, deeper sleep=5. Exactly one bit of the state output is set at any time. Core clock enable, bus clock enable and snoop flag are 1 and the break flag is 0.
- R2: A halt request in normal moves to halt on the next edge. An interrupt in halt returns to normal on the next edge.
- R3: With the stop-clock request held continuously from normal or halt, stop-grant is shown after the STPGNT_DELAY-th rising edge (20 by default) and not before.
- R4: If the stop-clock request drops before the delay completes, the count restarts from zero and a new request again needs the full delay.
- R5: Releasing the stop-clock request in stop-grant returns to halt if stop-grant was entered from halt, and to normal otherwise.
- R6: A sleep request moves stop-grant to sleep on the next edge and is ignored in every other state. Dropping it in sleep returns to stop-grant.
- R7: A deep-sleep request moves sleep to deep sleep and is ignored elsewhere. Its release returns deep sleep to sleep.
- R8: A deeper-sleep request moves deep sleep to deeper sleep and is ignored elsewhere. Its release returns to deep sleep.
- R9: A system-management interrupt pulse in normal or halt leads to normal. A later resume pulse returns to the state that was active when the interrupt was taken.
- R10: An interrupt seen while the stop-clock request is asserted sets the break flag. The flag stays set until the stop-clock request is released, and it is never set while that request is low.
- R11: The core clock enable is 1 only in normal. The bus clock enable and the snoop flag are 1 in normal, halt and stop-grant, and 0 in sleep, deep sleep and deeper sleep.
- R12: Asserting reset forces normal at once, without waiting for a clock edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Core executed a halt |
| intr | input | 1 | Interrupt or break event |
| stpclk_req | input | 1 | Stop-clock request, level |
| slp_req | input | 1 | Sleep request, level |
| dpslp_req | input | 1 | Deep-sleep request, level |
| dprslp_req | input | 1 | Deeper-sleep request, level |
| smi_req | input | 1 | System-management interrupt, pulse |
| smi_rsm | input | 1 | System-management handler done, pulse |
| pstate | output | 6 | One-hot present state |
| core_clk_en | output | 1 | Core clock gate enable |
| bus_clk_en | output | 1 | Bus-interface clock gate enable |
| snoop_ok | output | 1 | Snoops may be accepted |
| break_pend | output | 1 | Break event pending during stop-clock |

## Verification
The bench uses the defaults: a stop-grant delay of 20 clocks, and snoops accepted in stop-grant. With these values, the edge on which stop-grant appears can be pinned exactly. The count can also be aborted at 19 clocks to show that it restarts. The full descent to deeper sleep and the climb back fit in a few dozen cycles. Reset is asserted between edges while the machine is in deeper sleep, which shows that the return to normal does not wait for a clock.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int unsigned NUM_ST = 6;
   typedef logic [NUM_ST-1:0] pstate_t;

   localparam int unsigned IX_NORM   = 0;
   localparam int unsigned IX_HALT   = 1;
   localparam int unsigned IX_SG     = 2;
   localparam int unsigned IX_SLP    = 3;
   localparam int unsigned IX_DEEP   = 4;
   localparam int unsigned IX_DEEPER = 5;

   localparam pstate_t ST_NORM   = pstate_t'(1) << IX_NORM;
   localparam pstate_t ST_HALT   = pstate_t'(1) << IX_HALT;
   localparam pstate_t ST_SG     = pstate_t'(1) << IX_SG;
   localparam pstate_t ST_SLP    = pstate_t'(1) << IX_SLP;
   localparam pstate_t ST_DEEP   = pstate_t'(1) << IX_DEEP;
   localparam pstate_t ST_DEEPER = pstate_t'(1) << IX_DEEPER;
endpackage

// File: rtl/clkctl_sg_timer.sv
module clkctl_sg_timer #(
   parameter int unsigned DELAY = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic count_en,
   output logic done
);
   localparam int unsigned CW = $clog2(DELAY + 1);
   localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

   logic [CW-1:0] cnt;

   initial begin
      assert (DELAY >= 1) else $error("clkctl_sg_timer: DELAY must be at least 1");
   end

   assign done = count_en && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (!count_en) cnt <= '0;
      else if (!done)     cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/clkctl_state_seq.sv
module clkctl_state_seq
   import clkctl_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sg_done,
   input  logic    halt_req,
   input  logic    intr,
   input  logic    stpclk_req,
   input  logic    slp_req,
   input  logic    dpslp_req,
   input  logic    dprslp_req,
   input  logic    smi_req,
   input  logic    smi_rsm,
   output pstate_t st
);
   pstate_t nx;
   logic    smm, nx_smm;
   logic    org_halt, nx_org;
   logic    ret_halt, nx_ret;

   always_comb begin
      nx     = st;
      nx_smm = smm;
      nx_org = org_halt;
      nx_ret = ret_halt;
      case (st)
         ST_NORM: begin
            if (sg_done) begin
               nx     = ST_SG;
               nx_org = 1'b0;
            end else if (smi_req && !smm) begin
               nx_smm = 1'b1;
               nx_ret = 1'b0;
            end else if (smm && smi_rsm) begin
               nx_smm = 1'b0;
               nx     = ret_halt ? ST_HALT : ST_NORM;
            end else if (halt_req && !smm) begin
               nx = ST_HALT;
            end
         end
         ST_HALT: begin
            if (sg_done) begin
               nx     = ST_SG;
               nx_org = 1'b1;
            end else if (smi_req) begin
               nx     = ST_NORM;
               nx_smm = 1'b1;
               nx_ret = 1'b1;
            end else if (intr) begin
               nx = ST_NORM;
            end
         end
         ST_SG: begin
            if (!stpclk_req)  nx = org_halt ? ST_HALT : ST_NORM;
            else if (slp_req) nx = ST_SLP;
         end
         ST_SLP: begin
            if (dpslp_req)     nx = ST_DEEP;
            else if (!slp_req) nx = ST_SG;
         end
         ST_DEEP: begin
            if (dprslp_req)      nx = ST_DEEPER;
            else if (!dpslp_req) nx = ST_SLP;
         end
         ST_DEEPER: begin
            if (!dprslp_req) nx = ST_DEEP;
         end
         default: begin
            nx     = ST_NORM;
            nx_smm = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_NORM;
         smm      <= 1'b0;
         org_halt <= 1'b0;
         ret_halt <= 1'b0;
      end else begin
         st       <= nx;
         smm      <= nx_smm;
         org_halt <= nx_org;
         ret_halt <= nx_ret;
      end
   end
endmodule

// File: rtl/clkctl_out_dec.sv
module clkctl_out_dec
   import clkctl_pkg::*;
#(
   parameter bit SNOOP_IN_SG = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  pstate_t st,
   input  logic    stpclk_req,
   input  logic    intr,
   output logic    core_clk_en,
   output logic    bus_clk_en,
   output logic    snoop_ok,
   output logic    break_pend
);
   logic pend;

   assign core_clk_en = st[IX_NORM];
   assign bus_clk_en  = st[IX_NORM] | st[IX_HALT] | st[IX_SG];

   generate
      if (SNOOP_IN_SG) begin : g_snp_sg
         assign snoop_ok = st[IX_NORM] | st[IX_HALT] | st[IX_SG];
      end else begin : g_snp_run
         assign snoop_ok = st[IX_NORM] | st[IX_HALT];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend <= 1'b0;
      else if (!stpclk_req) pend <= 1'b0;
      else if (intr)        pend <= 1'b1;
   end

   assign break_pend = pend & stpclk_req;
endmodule

// File: rtl/clkctl_pwr_fsm.sv
module clkctl_pwr_fsm
   import clkctl_pkg::*;
#(
   parameter int unsigned STPGNT_DELAY = 20,
   parameter bit          SNOOP_IN_SG  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_req,
   input  logic       intr,
   input  logic       stpclk_req,
   input  logic       slp_req,
   input  logic       dpslp_req,
   input  logic       dprslp_req,
   input  logic       smi_req,
   input  logic       smi_rsm,
   output logic [5:0] pstate,
   output logic       core_clk_en,
   output logic       bus_clk_en,
   output logic       snoop_ok,
   output logic       break_pend
);
   pstate_t st;
   logic    sg_done;
   logic    sg_count_en;

   assign sg_count_en = stpclk_req & (st[IX_NORM] | st[IX_HALT]);

   clkctl_sg_timer #(.DELAY(STPGNT_DELAY)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (sg_count_en),
      .done     (sg_done)
   );

   clkctl_state_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sg_done    (sg_done),
      .halt_req   (halt_req),
      .intr       (intr),
      .stpclk_req (stpclk_req),
      .slp_req    (slp_req),
      .dpslp_req  (dpslp_req),
      .dprslp_req (dprslp_req),
      .smi_req    (smi_req),
      .smi_rsm    (smi_rsm),
      .st         (st)
   );

   clkctl_out_dec #(.SNOOP_IN_SG(SNOOP_IN_SG)) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .st          (st),
      .stpclk_req  (stpclk_req),
      .intr        (intr),
      .core_clk_en (core_clk_en),
      .bus_clk_en  (bus_clk_en),
      .snoop_ok    (snoop_ok),
      .break_pend  (break_pend)
   );

   assign pstate = st;
endmodule

// File: rtl/clkctl_pwr_fsm_chk.sv
module clkctl_pwr_fsm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stpclk_req,
   input logic       slp_req,
   input logic       dpslp_req,
   input logic       dprslp_req,
   input logic [5:0] pstate,
   input logic       core_clk_en,
   input logic       bus_clk_en,
   input logic       break_pend
);
   a_r1_onehot_state: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(pstate));

   a_r3_sg_needs_stpclk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pstate[2]) && !$past(pstate[3]) |-> $past(stpclk_req));

   a_r6_sleep_from_sg: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pstate[3]) |-> $past(pstate[2]) || $past(pstate[4]));

   a_r7_deep_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pstate[4]) |-> ($past(pstate[3]) && $past(dpslp_req)) || $past(pstate[5]));

   a_r8_deeper_from_deep: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pstate[5]) |-> $past(pstate[4]) && $past(dprslp_req));

   a_r10_break_needs_stpclk: assert property (@(posedge clk) disable iff (!rst_n)
      break_pend |-> stpclk_req);

   a_r11_core_only_normal: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en |-> pstate[0]);

   a_r11_bus_off_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate[3] || pstate[4] || pstate[5]) |-> !bus_clk_en);
endmodule

bind clkctl_pwr_fsm clkctl_pwr_fsm_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stpclk_req  (stpclk_req),
   .slp_req     (slp_req),
   .dpslp_req   (dpslp_req),
   .dprslp_req  (dprslp_req),
   .pstate      (pstate),
   .core_clk_en (core_clk_en),
   .bus_clk_en  (bus_clk_en),
   .break_pend  (break_pend)
);

// File: tb/clkctl_pwr_fsm_bench.sv
module clkctl_pwr_fsm_bench;
   localparam int DLY = 20;
   localparam logic [5:0] S_NORM = 6'b000001, S_HALT = 6'b000010, S_SG = 6'b000100,
                          S_SLP = 6'b001000, S_DEEP = 6'b010000, S_DEEPER = 6'b100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_req = 0, intr = 0, stpclk_req = 0, slp_req = 0;
   logic dpslp_req = 0, dprslp_req = 0, smi_req = 0, smi_rsm = 0;
   logic [5:0] pstate;
   logic core_clk_en, bus_clk_en, snoop_ok, break_pend;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   clkctl_pwr_fsm u_clkctl_pwr_fsm (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .intr(intr),
      .stpclk_req(stpclk_req), .slp_req(slp_req), .dpslp_req(dpslp_req),
      .dprslp_req(dprslp_req), .smi_req(smi_req), .smi_rsm(smi_rsm),
      .pstate(pstate), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
      .snoop_ok(snoop_ok), .break_pend(break_pend)
   );

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // advance n rising edges, then sample 2 ns later
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 0;
      {halt_req, intr, stpclk_req, slp_req, dpslp_req, dprslp_req, smi_req, smi_rsm} = '0;
      tick(2);
      rst_n = 1;
      tick(1);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 state", pstate, S_NORM);
      chk("R1 enables", {2'b0, core_clk_en, bus_clk_en, snoop_ok, break_pend}, 6'b001110);
   endtask

   task automatic t_halt();
      do_reset();
      halt_req = 1; tick(1); halt_req = 0;
      chk("R2 halt", pstate, S_HALT);
      chk("R11 halt enables", {3'b0, core_clk_en, bus_clk_en, snoop_ok}, 6'b000011);
      intr = 1; tick(1); intr = 0;
      chk("R2 wake", pstate, S_NORM);
   endtask

   task automatic t_sg_delay();
      do_reset();
      stpclk_req = 1;
      tick(DLY - 1);
      chk("R3 before delay", pstate, S_NORM);
      tick(1);
      chk("R3 at delay", pstate, S_SG);
      chk("R11 sg enables", {3'b0, core_clk_en, bus_clk_en, snoop_ok}, 6'b000011);
      stpclk_req = 0; tick(1);
      chk("R5 back to normal", pstate, S_NORM);
   endtask

   task automatic t_sg_abort();
      do_reset();
      stpclk_req = 1; tick(DLY - 1);
      stpclk_req = 0; tick(1);
      stpclk_req = 1; tick(DLY - 1);
      chk("R4 restarted count", pstate, S_NORM);
      tick(1);
      chk("R4 full delay", pstate, S_SG);
      stpclk_req = 0; tick(1);
   endtask

   task automatic t_halt_origin();
      do_reset();
      halt_req = 1; tick(1); halt_req = 0;
      stpclk_req = 1; tick(DLY);
      chk("R3 from halt", pstate, S_SG);
      stpclk_req = 0; tick(1);
      chk("R5 back to halt", pstate, S_HALT);
   endtask

   task automatic t_ignored();
      do_reset();
      slp_req = 1; dpslp_req = 1; dprslp_req = 1; tick(3);
      chk("R6 R7 R8 ignored in normal", pstate, S_NORM);
      slp_req = 0; dpslp_req = 0; dprslp_req = 0;
      stpclk_req = 1; tick(DLY);
      dpslp_req = 1; dprslp_req = 1; tick(2);
      chk("R7 ignored in stop-grant", pstate, S_SG);
      dpslp_req = 0; dprslp_req = 0; stpclk_req = 0; tick(1);
   endtask

   task automatic t_ladder();
      do_reset();
      stpclk_req = 1; tick(DLY);
      slp_req = 1; tick(1);
      chk("R6 sleep", pstate, S_SLP);
      chk("R11 sleep enables", {3'b0, core_clk_en, bus_clk_en, snoop_ok}, 6'b000000);
      dpslp_req = 1; tick(1);
      chk("R7 deep", pstate, S_DEEP);
      dprslp_req = 1; tick(1);
      chk("R8 deeper", pstate, S_DEEPER);
      dprslp_req = 0; tick(1);
      chk("R8 release", pstate, S_DEEP);
      dpslp_req = 0; tick(1);
      chk("R7 release", pstate, S_SLP);
      slp_req = 0; tick(1);
      chk("R6 release", pstate, S_SG);
      stpclk_req = 0; tick(1);
      chk("R5 after ladder", pstate, S_NORM);
   endtask

   task automatic t_smi();
      do_reset();
      halt_req = 1; tick(1); halt_req = 0;
      smi_req = 1; tick(1); smi_req = 0;
      chk("R9 handler runs", pstate, S_NORM);
      tick(2);
      smi_rsm = 1; tick(1); smi_rsm = 0;
      chk("R9 resume halt", pstate, S_HALT);
      intr = 1; tick(1); intr = 0;
      smi_req = 1; tick(1); smi_req = 0;
      smi_rsm = 1; tick(1); smi_rsm = 0;
      chk("R9 resume normal", pstate, S_NORM);
   endtask

   task automatic t_break();
      do_reset();
      intr = 1; tick(1); intr = 0;
      chk("R10 no stpclk", {5'b0, break_pend}, 6'd0);
      stpclk_req = 1; tick(DLY);
      chk("R10 idle", {5'b0, break_pend}, 6'd0);
      intr = 1; tick(1); intr = 0; tick(2);
      chk("R10 flagged", {5'b0, break_pend}, 6'd1);
      stpclk_req = 0; #1;
      chk("R10 cleared", {5'b0, break_pend}, 6'd0);
      tick(1);
   endtask

   task automatic t_async_reset();
      do_reset();
      stpclk_req = 1; tick(DLY);
      slp_req = 1; dpslp_req = 1; dprslp_req = 1; tick(3);
      chk("R12 reached deeper", pstate, S_DEEPER);
      #1 rst_n = 0; #1;
      chk("R12 immediate", pstate, S_NORM);
      {stpclk_req, slp_req, dpslp_req, dprslp_req} = '0;
      tick(1); rst_n = 1; tick(1);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_halt();
      t_sg_delay();
      t_sg_abort();
      t_halt_origin();
      t_ignored();
      t_ladder();
      t_smi();
      t_break();
      t_async_reset();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule